// File: doc/BRIEF.md
# Multi-Source Fault Protection Unit

This block gathers the protection signals of a switching power stage and turns them into two kinds of action. A fast primary-current comparator bit ends the present switching cycle for as long as it is high; this limits current cycle by cycle and never stops the converter. Two other sources can stop it and keep it stopped:

- **Secondary over-current path.** A digitized secondary current sample is compared against a programmable limit. The over-current condition must then persist for a programmable number of clocks before it trips.
- **External fault pin.** An active-high pin is synchronized to the clock and must be seen high at two consecutive clock edges before it trips.

Either trip sets a latched shutdown that holds until an explicit clear. A small register records which of the two latching sources caused the shutdown. Faults that arrive later cannot overwrite that record. The PWM stage consumes the cycle-terminate and shutdown outputs. Firmware or a supervisor reads the first-fault code and issues the clear.

Top module: `fault_guard`

## Requirements
- R1: While `rst_n` is low, at the clock edge, `cyc_end_o`, `shutdown_o` and `first_id_o` become 0.
- R2: `cyc_end_o` equals the value `pri_trip_i` had at the previous clock edge. It never sets `shutdown_o` by itself.
- R3: A valid sample counts as over the limit when `adc_data_i` is greater than or equal to `oc_limit_i`; equality is over.
- R4: Let a valid over-limit sample arrive at edge e, starting a run, with `dbnc_len_i` = L. If no valid below-limit sample arrives at edges e+1 through e+L, `shutdown_o` is high after edge e+L+1.
- R5: A valid below-limit sample ends the run and restarts the debounce count from zero.
- R6: `ext_fault_i` trips only when it is high at two consecutive clock edges; high at edges k and k+1 gives `shutdown_o` high after edge k+3. A pulse seen at one edge only has no effect.
- R7: Once set, `shutdown_o` stays high while `clear_i` is low, even after every source has gone away.
- R8: `first_id_o` is 0 with no shutdown, 1 (code for secondary over-current) or 2 (code for the external pin) when a shutdown is latched. If both trip at the same edge, code 2 is stored.
- R9: While a shutdown is latched, later trips leave `first_id_o` unchanged.
- R10: `clear_i` high at an edge drops `shutdown_o` and `first_id_o` to 0, even if a trip is pending at that same edge. A source that still trips latches again at the next edge.
- R11: Samples presented while `adc_valid_i` is low have no effect on the debounce state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_trip_i | input | 1 | Fast primary over-current comparator bit |
| adc_data_i | input | ADC_W | Secondary current sample |
| adc_valid_i | input | 1 | Sample strobe |
| oc_limit_i | input | ADC_W | Secondary over-current limit |
| dbnc_len_i | input | DBNC_W | Debounce length in clocks |
| ext_fault_i | input | 1 | External active-high fault pin, asynchronous |
| clear_i | input | 1 | Clears the latched shutdown and the fault code |
| cyc_end_o | output | 1 | Terminate the present switching cycle |
| shutdown_o | output | 1 | Latched shutdown to the PWM stage |
| first_id_o | output | 2 | First-fault code: 0 none, 1 secondary, 2 external |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Sample exactly at the limit.** A strict comparison would never trip on this sample.
- **Debounce window edges.** A below-limit sample is placed inside the window, and the trip edge is checked for lengths of zero and above. An off-by-one counter would shut down a clock early or late, and a counter that does not restart would trip on broken runs.
- **External pin pulses.** A pin high at a single edge must be rejected, while two edges must trip. A missing qualifier would latch on the glitch.
- **Clear and trips at the same edge.** The bench lines up both sources so they trip together, and pairs a clear with a pending trip. Wrong priority would record the secondary code instead of the external one, or would leave the shutdown set through a clear.

Random sample streams with invalid strobes and late second faults are also applied. These would expose a design that counts unstrobed samples or overwrites the first-fault code.

// File: rtl/fg_pkg.sv
// Shared types of the fault protection unit.
// Assumes: first-fault codes are consumed as a plain 2-bit number.
package fg_pkg;
    typedef enum logic [1:0] {
        FF_NONE = 2'd0,
        FF_SEC  = 2'd1,
        FF_EXT  = 2'd2
    } ff_id_e;
endpackage

// File: rtl/fg_cbc.sv
// Cycle-by-cycle limit stage: retimes the fast comparator bit into a
// cycle-terminate request, one clock later, without any memory of past trips.
// Assumes: the comparator bit is already timed to clk by the analog front end.
module fg_cbc (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    output logic end_o
);
    logic end_q;

    // Purpose: register the comparator bit; no latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b0;
        end else begin
            end_q <= cmp_i;
        end
    end

    assign end_o = end_q;
endmodule

// File: rtl/fg_sec_debounce.sv
// Secondary over-current qualifier: compares strobed samples against a limit
// (equal counts as over) and raises a trip once the over condition has lasted
// len clocks since the first over sample of the run.
// Assumes: len changes only between runs; the counter saturates.
module fg_sec_debounce #(
    parameter int ADC_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] smp_i,
    input  logic             smp_vld_i,
    input  logic [ADC_W-1:0] limit_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             trip_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_or_above;

    assign at_or_above = (smp_i >= limit_i);

    // Purpose: track the current over-limit run and its age in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (smp_vld_i && !at_or_above) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (smp_vld_i && !run_q) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign trip_o = run_q && (cnt_q >= len_i);
endmodule

// File: rtl/fg_ext_filter.sv
// External fault qualifier: synchronizes the asynchronous pin through SYNC_N
// flops, then demands two consecutive high synchronized values.
// Assumes: SYNC_N >= 1; the pin is active high.
module fg_ext_filter #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic trip_o
);
    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] sh_q;

    // Purpose: synchronizer chain plus one extra stage for the two-clock check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], pin_i};
        end
    end

    assign trip_o = sh_q[SH_W-1] && sh_q[SH_W-2];
endmodule

// File: rtl/fg_latch.sv
// Shutdown latch and first-fault register. The first trip sets shutdown and
// stores its source; the external pin wins a tie. Clear has priority.
// Assumes: trips are already qualified and synchronous to clk.
module fg_latch
    import fg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_trip_i,
    input  logic       ext_trip_i,
    input  logic       clr_i,
    output logic       shut_o,
    output logic [1:0] id_o
);
    logic   shut_q;
    ff_id_e id_q;

    // Purpose: latch the first fault and hold it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_q <= 1'b0;
            id_q   <= FF_NONE;
        end else if (clr_i) begin
            shut_q <= 1'b0;
            id_q   <= FF_NONE;
        end else if (!shut_q && (sec_trip_i || ext_trip_i)) begin
            shut_q <= 1'b1;
            id_q   <= ext_trip_i ? FF_EXT : FF_SEC;
        end
    end

    assign shut_o = shut_q;
    assign id_o   = id_q;
endmodule

// File: rtl/fault_guard.sv
// Multi-source fault protection unit: cycle-by-cycle limit from the fast
// comparator, debounced secondary over-current, qualified external pin,
// latched shutdown and first-fault code.
// Assumes: one clock domain; only ext_fault_i is asynchronous.
module fault_guard #(
    parameter int ADC_W  = 12,
    parameter int DBNC_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_trip_i,
    input  logic [ADC_W-1:0]  adc_data_i,
    input  logic              adc_valid_i,
    input  logic [ADC_W-1:0]  oc_limit_i,
    input  logic [DBNC_W-1:0] dbnc_len_i,
    input  logic              ext_fault_i,
    input  logic              clear_i,
    output logic              cyc_end_o,
    output logic              shutdown_o,
    output logic [1:0]        first_id_o
);
    logic sec_trip;
    logic ext_trip;

    fg_cbc u_cbc (
        .clk   (clk),
        .rst_n (rst_n),
        .cmp_i (pri_trip_i),
        .end_o (cyc_end_o)
    );

    fg_sec_debounce #(
        .ADC_W (ADC_W),
        .CNT_W (DBNC_W)
    ) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (adc_data_i),
        .smp_vld_i (adc_valid_i),
        .limit_i   (oc_limit_i),
        .len_i     (dbnc_len_i),
        .trip_o    (sec_trip)
    );

    fg_ext_filter #(
        .SYNC_N (SYNC_N)
    ) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_fault_i),
        .trip_o (ext_trip)
    );

    fg_latch u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_trip_i (sec_trip),
        .ext_trip_i (ext_trip),
        .clr_i      (clear_i),
        .shut_o     (shutdown_o),
        .id_o       (first_id_o)
    );
endmodule

// File: rtl/fg_checker.sv
// Property checker for fault_guard, attached with bind below.
// Assumes: sec_trip and ext_trip are the qualified trips inside the top.
module fg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pri_trip_i,
    input logic       clear_i,
    input logic       cyc_end_o,
    input logic       shutdown_o,
    input logic [1:0] first_id_o,
    input logic       sec_trip,
    input logic       ext_trip
);
    p_cyc_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cyc_end_o == $past(pri_trip_i)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_o && !clear_i) |=> shutdown_o);

    p_id_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_o && !clear_i) |=> $stable(first_id_o));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!shutdown_o && first_id_o == 2'd0));

    p_id_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> (first_id_o == 2'd1 || first_id_o == 2'd2));

    p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_o |-> (first_id_o == 2'd0));

    p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> $past(sec_trip || ext_trip));

    p_ext_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shutdown_o) && $past(ext_trip)) |-> (first_id_o == 2'd2));
endmodule

bind fault_guard fg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pri_trip_i (pri_trip_i),
    .clear_i    (clear_i),
    .cyc_end_o  (cyc_end_o),
    .shutdown_o (shutdown_o),
    .first_id_o (first_id_o),
    .sec_trip   (sec_trip),
    .ext_trip   (ext_trip)
);

// File: tb/sim_fault_guard.sv
// Bench for fault_guard: directed corner cases then seeded random stimulus,
// each edge checked against a requirement-level model kept in the bench.
module sim_fault_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pri = 1'b0;
    logic [11:0] adc = '0;
    logic        vld = 1'b0;
    logic [11:0] lim = 12'd100;
    logic [15:0] dlen = '0;
    logic        ext = 1'b0;
    logic        clr = 1'b0;
    logic        cyc_end;
    logic        shut;
    logic [1:0]  fid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // requirement-level model state
    int       n = 0;
    bit       m_run = 1'b0;
    int       m_t0 = 0;
    bit [2:0] m_eh = '0;
    bit       m_sd = 1'b0;
    bit [1:0] m_id = '0;
    bit       m_cyc = 1'b0;

    always #4 clk = ~clk;

    fault_guard u0 (
        .clk (clk), .rst_n (rst_n), .pri_trip_i (pri),
        .adc_data_i (adc), .adc_valid_i (vld), .oc_limit_i (lim),
        .dbnc_len_i (dlen), .ext_fault_i (ext), .clear_i (clr),
        .cyc_end_o (cyc_end), .shutdown_o (shut), .first_id_o (fid)
    );

    // Apply the requirements to the inputs present at one edge.
    function automatic void model_edge();
        bit st;
        bit et;
        if (!rst_n) begin
            m_run = 1'b0; m_eh = '0; m_sd = 1'b0; m_id = 2'd0; m_cyc = 1'b0;
        end else begin
            st = m_run && ((n - m_t0) > int'(dlen));   // R4
            et = m_eh[2] && m_eh[1];                     // R6
            if (vld && (adc < lim)) m_run = 1'b0;        // R3, R5
            else if (vld && !m_run) begin                // R11: only strobed samples
                m_run = 1'b1; m_t0 = n;
            end
            m_eh = {m_eh[1:0], ext};
            if (clr) begin                               // R10
                m_sd = 1'b0; m_id = 2'd0;
            end else if (!m_sd && (st || et)) begin      // R7, R8, R9
                m_sd = 1'b1; m_id = et ? 2'd2 : 2'd1;
            end
            m_cyc = pri;                                 // R2
        end
        n++;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        cmp(tag, "cyc_end", int'(cyc_end), int'(m_cyc));
        cmp(tag, "shutdown", int'(shut), int'(m_sd));
        cmp(tag, "first_id", int'(fid), int'(m_id));
    endtask

    task automatic idle(input int k, input string tag);
        for (int i = 0; i < k; i++) step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(1234);
        #1;
        // R1 reset state, with the comparator held high
        pri = 1'b1;
        idle(3, "R1");
        rst_n = 1'b1; pri = 1'b0;
        idle(2, "R1");
        // R2 comparator pattern
        pri = 1'b1; step("R2"); pri = 1'b0; step("R2");
        pri = 1'b1; step("R2"); step("R2"); pri = 1'b0; step("R2");
        // R3 and R4: sample equal to limit, debounce 2
        dlen = 16'd2; adc = 12'd100; vld = 1'b1; step("R3");
        vld = 1'b0; idle(4, "R4");
        adc = 12'd20; vld = 1'b1; step("R5"); vld = 1'b0;
        clr = 1'b1; step("R10"); clr = 1'b0; idle(2, "R10");
        // R5: run broken inside the window
        dlen = 16'd3; adc = 12'd400; vld = 1'b1; step("R5");
        vld = 1'b0; step("R5");
        adc = 12'd99; vld = 1'b1; step("R5"); vld = 1'b0;
        idle(6, "R5");
        // R11: huge samples without strobe
        adc = 12'hFFF; idle(8, "R11");
        // R6: single-edge glitch, then a two-edge pulse
        ext = 1'b1; step("R6"); ext = 1'b0; idle(5, "R6");
        ext = 1'b1; step("R6"); step("R6"); ext = 1'b0; idle(3, "R6");
        // R9: secondary fault after the external one
        dlen = 16'd0; adc = 12'd300; vld = 1'b1; step("R9"); vld = 1'b0;
        idle(3, "R9");
        adc = 12'd10; vld = 1'b1; step("R9"); vld = 1'b0;
        clr = 1'b1; step("R10"); clr = 1'b0; idle(2, "R10");
        // R10: clear at the edge where a trip is pending
        adc = 12'd150; vld = 1'b1; step("R10"); vld = 1'b0;
        clr = 1'b1; step("R10"); clr = 1'b0; idle(2, "R10");
        adc = 12'd10; vld = 1'b1; step("R10"); vld = 1'b0;
        clr = 1'b1; step("R10"); clr = 1'b0; idle(2, "R10");
        // R8: both sources trip at the same edge
        ext = 1'b1; step("R8"); step("R8");
        ext = 1'b0; adc = 12'd200; vld = 1'b1; step("R8");
        vld = 1'b0; idle(3, "R8");
        adc = 12'd10; vld = 1'b1; step("R8"); vld = 1'b0;
        clr = 1'b1; step("R10"); clr = 1'b0; idle(2, "R10");
        // random phase
        for (int blk = 0; blk < 10; blk++) begin
            dlen = 16'($urandom_range(0, 5));
            lim  = 12'($urandom_range(50, 4000));
            for (int i = 0; i < 400; i++) begin
                pri = 1'($urandom_range(0, 1));
                vld = ($urandom_range(0, 1) == 0);
                adc = 12'(int'(lim) + $urandom_range(0, 16) - 9);
                if ($urandom_range(0, 5) == 0) ext = ~ext;
                clr = ($urandom_range(0, 39) == 0);
                step("R7");
            end
        end
        clr = 1'b0; vld = 1'b0; ext = 1'b0;
        idle(4, "R7");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule